// File: doc/BRIEF.md
# Four-Phase Handshake Transfer Stage

This block is a one-entry storage stage between two return-to-zero request/acknowledge channels. A producer raises `in_req` with a word on `in_data`; the stage captures the word and raises `in_ack`. A consumer sees `out_req` rise with the stored word on `out_data` and answers with `out_ack`. Both channels then return to zero before the next transfer.

The stage decides what to do on each clock by checking a short list of guarded rules in a fixed priority order, so at most one rule fires per cycle.

- **Capture rule (higher priority).** It takes an input token. When flow-through is enabled, its output-side guard is conditional. If the stage is full, the output must also be idle, and the stored word is handed on in the same cycle the new one is captured. If the stage is empty, the output state does not matter.
- **Offer rule (lower priority).** It presents the stored word on the output and marks the stage empty.

Reset is asserted asynchronously (active low) and released through a synchronizer. While the stage is in reset, `in_ack` is held high so that no token is taken. The storage and full flag load their configured start values.

Top module: `hs_handshake_stage`

## Requirements
- R1: While the stage is in reset, `in_ack` is 1, `out_req` is 0 and, with `OUT_KEEP`=0, `out_data` is 0.
- R2: `in_ack` drops to 0 on the clock after one where `in_req` is 0 and `in_ack` is 1. It stays at 1 as long as `in_req` stays at 1, so a request held high through reset is never taken.
- R3: A token is taken only when `in_req`=1, `in_ack`=0 and the stage can accept it. `in_ack` rises on the next clock and `in_data` is captured on that same clock.
- R4: `out_req` rises only from a cycle where `out_req`=0, `out_ack`=0 and the stage is full. At that moment `out_data` carries the most recently captured word.
- R5: On the clock after a cycle where `out_req`=1 and `out_ack`=1, `out_req` is 0. With `OUT_KEEP`=0, `out_data` is 0 at the same time.
- R6: `out_data` does not change while `out_req` stays at 1.
- R7: While the stage is full and the output is not idle, no input token is taken (`in_ack` stays 0).
- R8: The behaviour in a cycle where the stage is full, the output is idle and an input token is waiting depends on `FLOW_THROUGH`.
  - With `FLOW_THROUGH`=1, the stored word is offered and the new token is taken on the same clock.
  - With `FLOW_THROUGH`=0, only the offer happens, and the token is taken one clock later.
- R9: With `OUT_KEEP`=1, `out_data` keeps its value after `out_req` returns to 0.
- R10: With `INIT_FULL`=1, the first active clock after reset offers `LATCH_INIT` on `out_data` without any input transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_req | input | 1 | Input channel request |
| in_ack | output | 1 | Input channel acknowledge |
| in_data | input | max(DATA_W,1) | Input word (ignored when DATA_W is 0) |
| out_req | output | 1 | Output channel request |
| out_ack | input | 1 | Output channel acknowledge |
| out_data | output | max(DATA_W,1) | Output word |

## Verification
The bench builds two copies of the stage with 8-bit data. The first copy has flow-through on, data clearing on, and starts empty. It reaches the simultaneous offer-and-capture case, back-pressure on a full stage, and reset with the input request held high. The second copy has flow-through off, keeps its output data, and starts full with 0xA5. It reaches the initial offer with no input, data retention after completion, and the one-clock split between offer and capture when a full stage meets a waiting token.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Which guarded rule fired in a cycle (at most one)
  typedef enum logic [1:0] {
    RULE_IDLE    = 2'd0,
    RULE_CAPTURE = 2'd1,
    RULE_OFFER   = 2'd2
  } hs_rule_e;
endpackage

// File: rtl/hs_reset_sync.sv
module hs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hs_in_port.sv
module hs_in_port (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic take_i,
  output logic ack_o,
  output logic avail_o
);
  logic ack_q, ack_d;

  // Token offered and not yet acknowledged
  assign avail_o = req_i && !ack_q;

  always_comb begin
    ack_d = ack_q;
    if (take_i)              ack_d = 1'b1;
    else if (!req_i && ack_q) ack_d = 1'b0;
  end

  // Acknowledge is pre-asserted in reset so no token is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b1;
    else        ack_q <= ack_d;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/hs_out_port.sv
module hs_out_port #(
  parameter int DW   = 8,
  parameter bit KEEP = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          give_i,
  input  logic [DW-1:0] give_data_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [DW-1:0] data_o,
  output logic          idle_o
);
  logic          req_q, req_d;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;

  assign idle_o = !req_q && !ack_i;

  always_comb begin
    req_d   = req_q;
    data_d  = data_q;
    data_en = 1'b0;
    if (give_i) begin
      req_d   = 1'b1;
      data_d  = give_data_i;
      data_en = 1'b1;
    end else if (req_q && ack_i) begin
      req_d   = 1'b0;
      data_d  = '0;
      data_en = !KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  generate
    if (KEEP) begin : g_keep
      // No reset term: the word survives reset and completion
      always_ff @(posedge clk) begin
        if (data_en) data_q <= data_d;
      end
    end else begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (data_en) data_q <= data_d;
      end
    end
  endgenerate

  assign req_o  = req_q;
  assign data_o = data_q;
endmodule

// File: rtl/hs_rule_engine.sv
module hs_rule_engine
  import hs_pkg::*;
#(
  parameter int          DW        = 8,
  parameter bit          FLOW      = 1'b1,
  parameter bit          INIT_FULL = 1'b0,
  parameter logic [DW-1:0] INIT_VAL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_avail_i,
  input  logic [DW-1:0]  in_data_i,
  input  logic           out_idle_i,
  output logic           take_o,
  output logic           give_o,
  output logic [DW-1:0]  give_data_o,
  output hs_rule_e       rule_o
);
  logic [DW-1:0] store_q, store_d;
  logic          full_q, full_d;
  logic          out_guard;

  // Conditional output guard: only binding while the stage is full
  generate
    if (FLOW) begin : g_flow
      assign out_guard = full_q ? out_idle_i : 1'b1;
    end else begin : g_noflow
      assign out_guard = !full_q;
    end
  endgenerate

  always_comb begin
    store_d = store_q;
    full_d  = full_q;
    take_o  = 1'b0;
    give_o  = 1'b0;
    rule_o  = RULE_IDLE;
    if (in_avail_i && out_guard) begin
      rule_o  = RULE_CAPTURE;
      take_o  = 1'b1;
      give_o  = full_q;
      store_d = in_data_i;
      full_d  = 1'b1;
    end else if (full_q && out_idle_i) begin
      rule_o  = RULE_OFFER;
      give_o  = 1'b1;
      full_d  = 1'b0;
    end
  end

  assign give_data_o = store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= INIT_VAL;
      full_q  <= INIT_FULL;
    end else begin
      store_q <= store_d;
      full_q  <= full_d;
    end
  end
endmodule

// File: rtl/hs_handshake_stage.sv
module hs_handshake_stage
  import hs_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter bit          FLOW_THROUGH = 1'b1,
  parameter bit          INIT_FULL    = 1'b0,
  parameter logic [63:0] LATCH_INIT   = 64'd0,
  parameter bit          OUT_KEEP     = 1'b0,
  parameter int          SYNC_STAGES  = 2,
  localparam int         DW_E         = (DATA_W > 0) ? DATA_W : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_req,
  output logic            in_ack,
  input  logic [DW_E-1:0] in_data,
  output logic            out_req,
  input  logic            out_ack,
  output logic [DW_E-1:0] out_data
);
  logic            rst_sync_n;
  logic            in_avail, out_idle, take, give;
  logic [DW_E-1:0] in_data_eff, give_data;
  hs_rule_e        rule_now;

  // A zero-width channel carries only the handshake
  assign in_data_eff = (DATA_W > 0) ? in_data : '0;

  hs_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  hs_in_port u_in (
    .clk(clk), .rst_n(rst_sync_n), .req_i(in_req), .take_i(take),
    .ack_o(in_ack), .avail_o(in_avail)
  );

  hs_rule_engine #(
    .DW(DW_E), .FLOW(FLOW_THROUGH), .INIT_FULL(INIT_FULL),
    .INIT_VAL(LATCH_INIT[DW_E-1:0])
  ) u_rules (
    .clk(clk), .rst_n(rst_sync_n), .in_avail_i(in_avail),
    .in_data_i(in_data_eff), .out_idle_i(out_idle), .take_o(take),
    .give_o(give), .give_data_o(give_data), .rule_o(rule_now)
  );

  hs_out_port #(.DW(DW_E), .KEEP(OUT_KEEP)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .give_i(give), .give_data_i(give_data),
    .ack_i(out_ack), .req_o(out_req), .data_o(out_data), .idle_o(out_idle)
  );
endmodule

// File: rtl/hs_stage_chk.sv
module hs_stage_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_req,
  input logic          in_ack,
  input logic          out_req,
  input logic          out_ack,
  input logic [DW-1:0] out_data
);
  p_ack_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_req && in_ack) |=> !in_ack);

  p_ack_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && in_ack) |=> in_ack);

  p_take_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_req));

  p_offer_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> $past(!out_ack));

  p_req_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && out_ack) |=> !out_req);

  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && $past(out_req)) |-> $stable(out_data));
endmodule

bind hs_handshake_stage hs_stage_chk #(.DW(DW_E)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_req(in_req), .in_ack(in_ack),
  .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
);

// File: tb/hs_handshake_stage_tb_top.sv
`timescale 1ns/1ps
module hs_handshake_stage_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  int   n_checks = 0;
  int   n_fails  = 0;

  always #2.5 clk = ~clk;

  logic       a_in_req, a_in_ack, a_out_req, a_out_ack;
  logic [7:0] a_in_data, a_out_data;
  logic       b_in_req, b_in_ack, b_out_req, b_out_ack;
  logic [7:0] b_in_data, b_out_data;

  hs_handshake_stage #(.DATA_W(8), .FLOW_THROUGH(1'b1), .INIT_FULL(1'b0),
                       .OUT_KEEP(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_req(a_in_req), .in_ack(a_in_ack),
    .in_data(a_in_data), .out_req(a_out_req), .out_ack(a_out_ack),
    .out_data(a_out_data)
  );

  hs_handshake_stage #(.DATA_W(8), .FLOW_THROUGH(1'b0), .INIT_FULL(1'b1),
                       .LATCH_INIT(64'hA5), .OUT_KEEP(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .in_req(b_in_req), .in_ack(b_in_ack),
    .in_data(b_in_data), .out_req(b_out_req), .out_ack(b_out_ack),
    .out_data(b_out_data)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    a_in_req = 1'b1; a_in_data = 8'h00; a_out_ack = 1'b0;
    b_in_req = 1'b0; b_in_data = 8'h00; b_out_ack = 1'b0;
    tick(3);
    check("R1 in_ack in reset", a_in_ack, 1);
    check("R1 out_req in reset", a_out_req, 0);
    check("R1 out_data in reset", a_out_data, 0);
    rst_n = 1'b1;
    tick(5);
    check("R2 ack held while req high", a_in_ack, 1);
    check("R3 no take of stale req", a_out_req, 0);
    a_in_req = 1'b0;
    tick();
    check("R2 ack returns", a_in_ack, 0);
  endtask

  task automatic t_flow_path;
    a_in_data = 8'h3C; a_in_req = 1'b1;
    tick();
    check("R3 ack rises on take", a_in_ack, 1);
    check("R4 not yet offered", a_out_req, 0);
    a_in_req = 1'b0;
    tick();
    check("R2 ack clears", a_in_ack, 0);
    check("R4 offer req", a_out_req, 1);
    check("R4 offer data", a_out_data, 8'h3C);
    tick(3);
    check("R6 data stable", a_out_data, 8'h3C);
    // second token fills the now empty store while output busy
    a_in_data = 8'h5A; a_in_req = 1'b1;
    tick();
    check("R3 take while output busy", a_in_ack, 1);
    a_in_req = 1'b0;
    tick();
    a_in_data = 8'h77; a_in_req = 1'b1;
    tick(3);
    check("R7 full blocks take", a_in_ack, 0);
    check("R6 data still stable", a_out_data, 8'h3C);
    a_out_ack = 1'b1;
    tick();
    check("R5 req returns", a_out_req, 0);
    check("R5 data cleared", a_out_data, 0);
    check("R7 still blocked while ack high", a_in_ack, 0);
    a_out_ack = 1'b0;
    tick();
    check("R8 flow offer req", a_out_req, 1);
    check("R8 flow offer data", a_out_data, 8'h5A);
    check("R8 flow take same clock", a_in_ack, 1);
    a_in_req = 1'b0;
    tick();
    a_out_ack = 1'b1;
    tick();
    a_out_ack = 1'b0;
    tick();
    check("R4 third word offered", a_out_data, 8'h77);
  endtask

  task automatic t_keep_path;
    check("R10 initial offer req", b_out_req, 1);
    check("R10 initial offer data", b_out_data, 8'hA5);
    check("R2 preset ack cleared", b_in_ack, 0);
    b_in_data = 8'h11; b_in_req = 1'b1;
    tick();
    check("R3 take into empty store", b_in_ack, 1);
    b_in_req = 1'b0;
    tick();
    b_in_data = 8'h22; b_in_req = 1'b1;
    tick(2);
    check("R7 blocked while full", b_in_ack, 0);
    b_out_ack = 1'b1;
    tick();
    check("R5 req returns", b_out_req, 0);
    check("R9 data kept", b_out_data, 8'hA5);
    b_out_ack = 1'b0;
    tick();
    check("R8 offer without take req", b_out_req, 1);
    check("R8 offer data", b_out_data, 8'h11);
    check("R8 no take same clock", b_in_ack, 0);
    tick();
    check("R8 take one clock later", b_in_ack, 1);
    b_in_req = 1'b0;
    tick();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_flow_path();
    t_keep_path();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule